// File: doc/BRIEF.md
# Adaptive Interrupt Acceptance Holdoff

This block decides on every cycle whether a pending interrupt may be taken by the core. It sits between the interrupt request input and the logic that redirects fetch to a handler. When an interrupt has to be deferred because an instruction still in flight has turned interrupts off, the block starts a holdoff. The holdoff is a down-counter that moves only on cycles where the pipeline front end advances. Until it drains, acceptance stays blocked. This gives the disabling code time to make progress, so the core does not keep flushing and refetching handler code.

The value loaded into the counter is a base that adapts. The commit stage reports each time it meets the interrupt while interrupts are off, and each report raises the base by a fixed step. An interrupt-enable instruction sets the base back to its minimum. If a report would push the base past a limit, the interrupt is treated as stuck. A one-cycle exception pulse is raised and the base returns to the minimum.

Top module: `irq_holdoff`

## Requirements
- R1: On synchronous reset (rst high at a clock edge), the base becomes MIN_HOLD, the holdoff counter becomes zero and stuck_exc is low.
- R2: irq_accept is high exactly when irq_pending and irq_enabled are both high and the holdoff counter is zero.
- R3: A cycle with defer_evt high loads the counter with the current base at the next edge. The load wins over a decrement in the same cycle.
- R4: Without defer_evt, the counter decrements by one at an edge only if fe_advance is high and the counter is non-zero. Otherwise it holds its value, so fetch stalls do not shorten the holdoff.
- R5: A cycle with commit_seen high and ei_exec low raises the base by HOLD_STEP when the result does not exceed HOLD_LIMIT.
- R6: The base never exceeds HOLD_LIMIT. A commit_seen report that would carry it past HOLD_LIMIT sets the base to MIN_HOLD and raises stuck_exc for exactly the following cycle.
- R7: ei_exec high sets the base to MIN_HOLD at the next edge and overrides a commit_seen report in the same cycle: that report neither raises the base nor raises stuck_exc.
- R8: Accepting an interrupt changes neither the counter nor the base. A later deferral therefore loads the same base as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_pending | input | 1 | An interrupt request is waiting |
| irq_enabled | input | 1 | Interrupts are currently enabled |
| defer_evt | input | 1 | A pending interrupt was deferred by an in-flight disable; starts a holdoff |
| fe_advance | input | 1 | The pipeline front end advanced this cycle |
| commit_seen | input | 1 | Commit found the interrupt while interrupts were disabled |
| ei_exec | input | 1 | An interrupt-enable instruction executed |
| irq_accept | output | 1 | The interrupt may be accepted this cycle |
| stuck_exc | output | 1 | One-cycle stuck-interrupt exception pulse |

## Verification
The bench builds the block with MIN_HOLD=3, HOLD_STEP=2 and HOLD_LIMIT=9. With these values a holdoff drains in a few front-end advances, and the base climbs 3, 5, 7, 9. The fourth commit report after a reset then trips the stuck exception. This brings saturation, the exception pulse and the return to the minimum within a short run. Front-end stalls inside a holdoff, a load and an advance in the same cycle, and an enable and a commit report in the same cycle are driven as directed cases.

// File: rtl/irq_holdoff_pkg.sv
package irq_holdoff_pkg;

  // Raw sum of the current base and one step, kept 32 bits wide so a
  // comparison against the limit cannot wrap.
  function automatic int unsigned hold_bump(input int unsigned base,
                                            input int unsigned step);
    return base + step;
  endfunction

  // True when a bumped base would pass the limit.
  function automatic logic hold_overflow(input int unsigned bumped,
                                         input int unsigned limit);
    return bumped > limit;
  endfunction

endpackage

// File: rtl/holdoff_base.sv
module holdoff_base
  import irq_holdoff_pkg::*;
#(
  parameter int unsigned MIN_HOLD   = 10,
  parameter int unsigned HOLD_STEP  = 10,
  parameter int unsigned HOLD_LIMIT = 1000,
  parameter int unsigned CW         = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ei_exec,
  input  logic          commit_seen,
  output logic [CW-1:0] base_o,
  output logic          stuck_o
);

  localparam logic [CW-1:0] MIN_V   = CW'(MIN_HOLD);
  localparam logic [CW-1:0] LIMIT_V = CW'(HOLD_LIMIT);

  logic [CW-1:0] base_q;
  logic          stuck_q;
  int unsigned   bumped_w;
  logic          bump_ovf_w;
  logic          bump_evt_w;

  assign bumped_w   = hold_bump(32'(base_q), HOLD_STEP);
  assign bump_ovf_w = hold_overflow(bumped_w, HOLD_LIMIT);
  assign bump_evt_w = commit_seen && !ei_exec;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= MIN_V;
      stuck_q <= 1'b0;
    end else begin
      stuck_q <= 1'b0;
      if (ei_exec) begin
        base_q <= MIN_V;
      end else if (commit_seen) begin
        if (bump_ovf_w) begin
          base_q  <= MIN_V;
          stuck_q <= 1'b1;
        end else begin
          base_q <= CW'(bumped_w);
        end
      end
    end
  end

  assign base_o  = base_q;
  assign stuck_o = stuck_q;

  // R6
  base_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    base_q <= LIMIT_V);

  // R6
  stuck_single_chk: assert property (@(posedge clk) disable iff (rst)
    stuck_q |=> !stuck_q);

  // R6
  stuck_min_chk: assert property (@(posedge clk) disable iff (rst)
    stuck_q |-> base_q == MIN_V);

  // R7
  enable_restore_chk: assert property (@(posedge clk) disable iff (rst)
    ei_exec |=> (base_q == MIN_V) && !stuck_q);

  // R5
  bump_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (bump_evt_w && !bump_ovf_w) |=> base_q > $past(base_q));

  // R5
  base_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!ei_exec && !commit_seen) |=> $stable(base_q));

endmodule

// File: rtl/holdoff_counter.sv
module holdoff_counter #(
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          adv,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;
  logic          dec_w;

  assign dec_w = adv && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (dec_w) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt_q == $past(load_val));

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && adv && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && (!adv || cnt_q == '0)) |=> $stable(cnt_q));

endmodule

// File: rtl/irq_holdoff.sv
module irq_holdoff #(
  parameter int unsigned MIN_HOLD   = 10,
  parameter int unsigned HOLD_STEP  = 10,
  parameter int unsigned HOLD_LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic irq_pending,
  input  logic irq_enabled,
  input  logic defer_evt,
  input  logic fe_advance,
  input  logic commit_seen,
  input  logic ei_exec,
  output logic irq_accept,
  output logic stuck_exc
);

  localparam int unsigned CW = $clog2(HOLD_LIMIT + 1);

  logic [CW-1:0] base_w;
  logic [CW-1:0] cnt_w;
  logic          cnt_zero_w;

  holdoff_base #(
    .MIN_HOLD  (MIN_HOLD),
    .HOLD_STEP (HOLD_STEP),
    .HOLD_LIMIT(HOLD_LIMIT),
    .CW        (CW)
  ) u_base (
    .clk        (clk),
    .rst        (rst),
    .ei_exec    (ei_exec),
    .commit_seen(commit_seen),
    .base_o     (base_w),
    .stuck_o    (stuck_exc)
  );

  holdoff_counter #(
    .CW(CW)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (defer_evt),
    .load_val(base_w),
    .adv     (fe_advance),
    .cnt_o   (cnt_w),
    .zero_o  (cnt_zero_w)
  );

  assign irq_accept = irq_pending && irq_enabled && cnt_zero_w;

  // R2
  defer_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (defer_evt && base_w != '0) |=> !irq_accept);

  // R8
  accept_keeps_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_accept && !defer_evt) |=> cnt_w == '0);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cnt_w == '0) && !stuck_exc && (base_w == CW'(MIN_HOLD)));

endmodule

// File: tb/test_irq_holdoff.sv
module test_irq_holdoff;

  localparam int CLK_PERIOD = 10;
  localparam int unsigned P_MIN = 3;
  localparam int unsigned P_STEP = 2;
  localparam int unsigned P_LIMIT = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_pending = 1'b0, irq_enabled = 1'b0, defer_evt = 1'b0;
  logic fe_advance = 1'b0, commit_seen = 1'b0, ei_exec = 1'b0;
  logic irq_accept, stuck_exc;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_holdoff #(
    .MIN_HOLD(P_MIN), .HOLD_STEP(P_STEP), .HOLD_LIMIT(P_LIMIT)
  ) i_irq_holdoff (
    .clk(clk), .rst(rst), .irq_pending(irq_pending), .irq_enabled(irq_enabled),
    .defer_evt(defer_evt), .fe_advance(fe_advance), .commit_seen(commit_seen),
    .ei_exec(ei_exec), .irq_accept(irq_accept), .stuck_exc(stuck_exc)
  );

  // Inputs {pend,en,defer,adv,seen,ei}, expected {accept,stuck} after the edge.
  typedef struct packed {
    logic [5:0] stim;
    logic [1:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{6'b110000, 2'b10, 4'd2},  // R2 idle, counter zero
    '{6'b101000, 2'b00, 4'd3},  // R3 deferral loads 3
    '{6'b110100, 2'b00, 4'd4},  // R4 3->2
    '{6'b110000, 2'b00, 4'd4},  // R4 stall holds 2
    '{6'b110100, 2'b00, 4'd4},  // R4 2->1
    '{6'b110100, 2'b10, 4'd4},  // R4 1->0
    '{6'b110100, 2'b10, 4'd4},  // R4 stays at zero
    '{6'b100010, 2'b00, 4'd5},  // R5 base 3->5
    '{6'b101000, 2'b00, 4'd5},  // R5 load 5
    '{6'b110100, 2'b00, 4'd5},  // 4
    '{6'b110100, 2'b00, 4'd5},  // 3
    '{6'b110100, 2'b00, 4'd5},  // 2
    '{6'b110100, 2'b00, 4'd5},  // 1
    '{6'b110100, 2'b10, 4'd5},  // R5 0 after five advances
    '{6'b000010, 2'b00, 4'd5},  // base 7
    '{6'b000010, 2'b00, 4'd6},  // R6 base 9 at limit
    '{6'b000010, 2'b01, 4'd6},  // R6 would pass limit: stuck pulse
    '{6'b000000, 2'b00, 4'd6},  // R6 pulse is one cycle
    '{6'b001000, 2'b00, 4'd6},  // R6 base back to 3
    '{6'b110100, 2'b00, 4'd6},  // 2
    '{6'b110100, 2'b00, 4'd6},  // 1
    '{6'b110100, 2'b10, 4'd6}   // R6 0
  };

  task automatic check(input logic act, input logic exp, input string what,
                       input int req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [5:0] s, input logic ea, input logic es,
                     input int req);
    @(negedge clk);
    {irq_pending, irq_enabled, defer_evt, fe_advance, commit_seen, ei_exec} = s;
    @(posedge clk);
    #1;
    check(irq_accept, ea, "irq_accept", req);
    check(stuck_exc, es, "stuck_exc", req);
  endtask

  // Advance n times with pending+enabled; accept only on the last.
  task automatic drain(input int n, input int req);
    for (int k = 0; k < n; k++)
      cyc(6'b110100, (k == n - 1), 1'b0, req);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state: counter zero, no pulse
    irq_pending = 1'b1; irq_enabled = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(irq_accept, 1'b1, "accept in reset", 1);
    check(stuck_exc, 1'b0, "stuck in reset", 1);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++)
      cyc(VECS[i].stim, VECS[i].exp[1], VECS[i].exp[0], int'(VECS[i].req));

    // R7 enable restores minimum: base 3 -> 5 -> 7, then enable
    cyc(6'b000010, 1'b0, 1'b0, 7);
    cyc(6'b000010, 1'b0, 1'b0, 7);
    cyc(6'b000001, 1'b0, 1'b0, 7);
    cyc(6'b101000, 1'b0, 1'b0, 7);
    drain(3, 7);

    // R7 enable beats a commit report in the same cycle
    cyc(6'b000011, 1'b0, 1'b0, 7);
    cyc(6'b101000, 1'b0, 1'b0, 7);
    drain(3, 7);

    // R3 load wins over advance in the same cycle
    cyc(6'b101100, 1'b0, 1'b0, 3);
    drain(3, 3);

    // R8 accepting for several cycles leaves the base unchanged
    cyc(6'b110000, 1'b1, 1'b0, 8);
    cyc(6'b110100, 1'b1, 1'b0, 8);
    cyc(6'b101000, 1'b0, 1'b0, 8);
    drain(3, 8);

    // R2 counter zero but disabled or not pending
    cyc(6'b010000, 1'b0, 1'b0, 2);
    cyc(6'b100000, 1'b0, 1'b0, 2);

    // R6 four reports trip the exception; the enable one cycle later is fine
    for (int k = 0; k < 3; k++) cyc(6'b000010, 1'b0, 1'b0, 6);
    cyc(6'b000010, 1'b0, 1'b1, 6);
    cyc(6'b000001, 1'b0, 1'b0, 6);

    // R1 mid-run reset clears a holdoff in progress
    cyc(6'b101000, 1'b0, 1'b0, 1);
    @(negedge clk);
    rst = 1'b1;
    {irq_pending, irq_enabled, defer_evt, fe_advance, commit_seen, ei_exec} = 6'b110000;
    @(posedge clk);
    #1;
    check(irq_accept, 1'b1, "accept after reset", 1);
    check(stuck_exc, 1'b0, "stuck after reset", 1);
    @(negedge clk);
    rst = 1'b0;
    cyc(6'b101000, 1'b0, 1'b0, 1);
    drain(3, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule